// File: doc/BRIEF.md
# Main Clock Stop Failover Controller

This block watches a main clock for loss of oscillation and, once detection is armed, moves the system clock selection over to an on-chip backup oscillator. The main clock is treated as a data input. A free-running reference clock samples it through a synchronizer, and a gap counter measures the time since the last main-clock transition. When that gap reaches a timeout of `TIMEOUT` reference cycles, the monitor flag sets. While detection is armed, the flag forces the clock-select bit to the backup oscillator.

Software reaches the block through one 8-bit control/status register with a write-strobe input and a write-unlock input. The select output drives an external glitch-free clock multiplexer. A second output asks for the low-speed oscillator to be kept running whenever the backup clock is selected. The select bit is sticky: while the monitor still reports the main clock as stopped, software cannot move the selection back to the main clock.

Top module: `clkfail_guard`

## Requirements
- R1: After reset the register reads 0x04: arm field 00, select bit 1, monitor bit 0, upper nibble 0. The oscillator request is 1.
- R2: A write, meaning `bus_wr` is 1 at a rising reference-clock edge, changes the register only when `wr_unlock` is also 1. Writes made while `wr_unlock` is 0 leave the register unchanged.
- R3: Bits 7..4 always read 0. Any value written to them is dropped.
- R4: The arm field occupies bits 1..0 and accepts only 00 (detection off) or 11 (detection on). A write carrying 01 or 10 leaves the arm field unchanged, and the write still updates bit 2.
- R5: With detection armed, a main clock that transitions at least once every `TIMEOUT`-1 reference cycles never sets the monitor bit.
- R6: With detection armed, a main clock that stops for more than `TIMEOUT` reference cycles (plus synchronizer latency) sets the monitor bit (bit 3) to 1 and forces the select bit (bit 2) to 1.
- R7: While the monitor bit is 1, an unlocked write of 0 to the select bit is ignored and the bit stays 1.
- R8: After the main clock resumes, the monitor bit clears once transitions have been seen continuously for a full `TIMEOUT` window. The select bit stays 1 until software writes 0.
- R9: While the arm field is 00, the monitor bit reads 0 even if the main clock is stopped, and the select bit can be written freely.
- R10: `osc_keep_on` equals the select bit at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock; all registers use it |
| rst_n | input | 1 | Synchronous active-low reset |
| main_clk | input | 1 | Main clock, sampled as asynchronous data |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| wr_unlock | input | 1 | Write-protect release; 1 permits writes |
| bus_rdata | output | 8 | Register read value {0000, monitor, select, arm[1:0]} |
| clk_sel_backup | output | 1 | 1 selects the on-chip oscillator clock |
| osc_keep_on | output | 1 | 1 requests the low-speed oscillator to run |

## Verification
On every cycle, the embedded assertions check four things. The arm field never holds a reserved code. An active monitor forces selection of the backup clock on the next edge. The register holds still when no unlocked write arrives. The detector flags a stop only after its gap counter has saturated, and it drops its flag one cycle after detection is disarmed. Only the bench scenarios can show the end-to-end timing: a running clock at both fast and near-timeout rates raises no alarm, a real stop is detected, software cannot clear the select bit while the stop persists, and recovery and disarming clear the monitor as required.

// File: rtl/clkmon_pkg.sv
// Package: shared register view and constants for the clock stop failover block.
// Assumes an 8-bit register whose low bits are decoded by software at fixed positions.
package clkmon_pkg;

    typedef struct packed {
        logic [3:0] rsvd;   // always zero
        logic       mon;    // bit 3: main clock stopped (read only)
        logic       sel;    // bit 2: 1 = backup oscillator clock
        logic [1:0] arm;    // bits 1..0: detection enable code
    } ctl_view_t;

    localparam logic [1:0] ARM_OFF   = 2'b00;
    localparam logic [1:0] ARM_ON    = 2'b11;
    localparam logic       SEL_RESET = 1'b1;

endpackage

// File: rtl/mclk_edge_sync.sv
// Module: mclk_edge_sync
// Brings the asynchronous main clock into the reference domain through a chain of
// STAGES flops and flags either transition with one extra flop. Assumes the
// reference clock is fast enough to see each main-clock level at least once.
module mclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic mclk_i,
    output logic edge_o
);
    logic [STAGES:0] chain_q;

    // Purpose: first synchronizer flop samples the raw main clock
    always_ff @(posedge ref_clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= mclk_i;
    end

    // Purpose: remaining synchronizer flops plus the edge-history flop
    for (genvar g = 1; g <= STAGES; g++) begin : g_chain
        always_ff @(posedge ref_clk) begin
            if (!rst_n) chain_q[g] <= 1'b0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign edge_o = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/stop_timer.sv
// Module: stop_timer
// Measures the gap since the last synchronized main-clock edge. It raises
// stopped_o once the gap saturates at TIMEOUT, and it clears stopped_o after
// edges have kept the gap short for TIMEOUT consecutive cycles. All state is
// held clear while detection is not armed.
module stop_timer #(
    parameter int TIMEOUT = 16
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic armed_i,
    input  logic edge_i,
    output logic stopped_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic [CW-1:0] gap_q;
    logic [CW-1:0] recov_q;
    logic          stopped_q;
    logic          live;

    assign live = (gap_q < LIMIT);

    // Purpose: gap counter, cleared on each edge and saturating at the timeout
    always_ff @(posedge ref_clk) begin
        if (!rst_n || !armed_i) gap_q <= '0;
        else if (edge_i)        gap_q <= '0;
        else if (gap_q != LIMIT) gap_q <= gap_q + 1'b1;
    end

    // Purpose: recovery counter, counts cycles of live clock while flagged stopped
    always_ff @(posedge ref_clk) begin
        if (!rst_n || !armed_i || !stopped_q) recov_q <= '0;
        else if (!live)                       recov_q <= '0;
        else if (recov_q != LIMIT)            recov_q <= recov_q + 1'b1;
    end

    // Purpose: stop flag, set on a saturated gap and cleared after a full live window
    always_ff @(posedge ref_clk) begin
        if (!rst_n || !armed_i)                 stopped_q <= 1'b0;
        else if (!stopped_q && gap_q == LIMIT)  stopped_q <= 1'b1;
        else if (stopped_q && recov_q == LIMIT) stopped_q <= 1'b0;
    end

    assign stopped_o = stopped_q;

    // R6: a stop is flagged only after the gap counter had saturated
    assert_stop_needs_gap_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(stopped_q) |-> $past(gap_q == LIMIT));

    // R9: disarming drops the stop flag on the next edge
    assert_disarm_clears_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !armed_i |=> !stopped_q);

    // R5: the gap counter never runs past the timeout
    assert_gap_bounded_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
        gap_q <= LIMIT);
endmodule

// File: rtl/ctl_reg.sv
// Module: ctl_reg
// Holds the arm field and the sticky clock-select bit. Assumes wr_en already
// combines the write strobe with the write-unlock input. An active monitor
// forces selection of the backup clock, and this overrides any software write.
module ctl_reg
    import clkmon_pkg::*;
(
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] wdata,
    input  logic       mon_i,
    output logic [1:0] arm_o,
    output logic       sel_o
);
    logic [1:0] arm_q;
    logic       sel_q;
    logic       code_ok;

    assign code_ok = (wdata[1:0] == ARM_OFF) || (wdata[1:0] == ARM_ON);

    // Purpose: arm field, accepting only the off and on codes
    always_ff @(posedge ref_clk) begin
        if (!rst_n)                arm_q <= ARM_OFF;
        else if (wr_en && code_ok) arm_q <= wdata[1:0];
    end

    // Purpose: select bit, forced to the backup clock while the monitor is set
    always_ff @(posedge ref_clk) begin
        if (!rst_n)      sel_q <= SEL_RESET;
        else if (mon_i)  sel_q <= 1'b1;
        else if (wr_en)  sel_q <= wdata[2];
    end

    assign arm_o = arm_q;
    assign sel_o = sel_q;

    // R4: the arm field never holds a reserved code
    assert_arm_legal_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
        arm_q == ARM_OFF || arm_q == ARM_ON);

    // R7: an active monitor leaves the backup clock selected
    assert_sel_sticky_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
        mon_i |=> sel_q);

    // R2: without an unlocked write the arm field holds its value
    assert_no_wr_hold_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !wr_en |=> $stable(arm_q));
endmodule

// File: rtl/clkfail_guard.sv
// Module: clkfail_guard (top)
// Clock stop detection with failover to the backup oscillator. The main clock
// is sampled as data in the reference domain. The register reads back as
// {0000, monitor, select, arm}, and writes need wr_unlock to be 1.
module clkfail_guard
    import clkmon_pkg::*;
#(
    parameter int TIMEOUT     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       main_clk,
    input  logic       bus_wr,
    input  logic [7:0] bus_wdata,
    input  logic       wr_unlock,
    output logic [7:0] bus_rdata,
    output logic       clk_sel_backup,
    output logic       osc_keep_on
);
    logic       mclk_edge;
    logic       stopped;
    logic       armed;
    logic       mon;
    logic [1:0] arm;
    logic       sel;
    logic       wr_en;
    logic       rsvd_unused;
    ctl_view_t  view;

    assign wr_en       = bus_wr && wr_unlock;
    assign armed       = (arm == ARM_ON);
    assign mon         = armed && stopped;
    assign rsvd_unused = ^bus_wdata[7:3];

    mclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .mclk_i  (main_clk),
        .edge_o  (mclk_edge)
    );

    stop_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .armed_i   (armed),
        .edge_i    (mclk_edge),
        .stopped_o (stopped)
    );

    ctl_reg u_reg (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wdata   (bus_wdata[2:0]),
        .mon_i   (mon),
        .arm_o   (arm),
        .sel_o   (sel)
    );

    // Purpose: assemble the read view with the reserved nibble tied low
    always_comb begin
        view.rsvd = 4'h0;
        view.mon  = mon;
        view.sel  = sel;
        view.arm  = arm;
    end

    assign bus_rdata      = view;
    assign clk_sel_backup = sel;
    assign osc_keep_on    = sel;

    // R10: the oscillator request follows the select output
    assert_osc_follows_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
        osc_keep_on == clk_sel_backup);
endmodule

// File: tb/sim_clkfail_guard.sv
module sim_clkfail_guard;
    localparam int CLK_PERIOD = 10;
    localparam int TO = 16;

    logic       ref_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_clk = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       wr_unlock = 1'b0;
    logic [7:0] bus_rdata;
    logic       clk_sel_backup;
    logic       osc_keep_on;

    int  n_checks = 0;
    int  n_fails = 0;
    int  mc_half = 23;
    bit  mc_run = 1'b0;

    typedef struct {
        logic [7:0] rd;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    clkfail_guard #(.TIMEOUT(TO), .SYNC_STAGES(2)) u0 (
        .ref_clk(ref_clk), .rst_n(rst_n), .main_clk(main_clk),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .wr_unlock(wr_unlock),
        .bus_rdata(bus_rdata), .clk_sel_backup(clk_sel_backup),
        .osc_keep_on(osc_keep_on)
    );

    always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

    // Main clock source: toggles every mc_half ns while mc_run is set
    initial begin
        forever begin
            #(mc_half);
            if (mc_run) main_clk = ~main_clk;
        end
    end

    // Monitor: pops an expected item on each falling edge and compares
    always @(negedge ref_clk) begin
        if (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            n_checks++;
            if (bus_rdata !== it.rd) begin
                n_fails++;
                $display("FAIL %s rdata actual=%02h expected=%02h", it.tag, bus_rdata, it.rd);
            end
            n_checks++;
            if (osc_keep_on !== it.rd[2] || clk_sel_backup !== it.rd[2]) begin
                n_fails++;
                $display("FAIL R10 (%s) osc/sel actual=%0b/%0b expected=%0b",
                         it.tag, osc_keep_on, clk_sel_backup, it.rd[2]);
            end
        end
    end

    task automatic do_write(input logic [7:0] d, input logic unl);
        @(negedge ref_clk);
        bus_wr = 1'b1; bus_wdata = d; wr_unlock = unl;
        @(negedge ref_clk);
        bus_wr = 1'b0; wr_unlock = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic expect_rd(input logic [7:0] r, input string tag);
        exp_t it;
        @(posedge ref_clk);
        #1;
        it.rd = r; it.tag = tag;
        exp_q.push_back(it);
        @(negedge ref_clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge ref_clk);
    endtask

    initial begin
        repeat (50000) @(posedge ref_clk);
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge ref_clk) rst_n = 1'b1;
        expect_rd(8'h04, "R1 reset value");

        do_write(8'h00, 1'b1);
        expect_rd(8'h00, "R2 unlocked write applies, R10 request off");
        do_write(8'h07, 1'b0);
        expect_rd(8'h00, "R2 locked write dropped");

        mc_run = 1'b1;
        do_write(8'hF3, 1'b1);
        expect_rd(8'h03, "R3 reserved bits dropped, arm on");
        idle(60);
        expect_rd(8'h03, "R5 fast running clock no alarm");

        do_write(8'h05, 1'b1);
        expect_rd(8'h07, "R4 code 01 keeps arm, select written");
        do_write(8'h02, 1'b1);
        expect_rd(8'h03, "R4 code 10 keeps arm, select cleared");

        mc_half = 140;
        idle(120);
        expect_rd(8'h03, "R5 near-timeout clock no alarm");

        mc_run = 1'b0;
        idle(2 * TO + 10);
        expect_rd(8'h0F, "R6 stop detected, select forced");
        do_write(8'h03, 1'b1);
        expect_rd(8'h0F, "R7 select clear ignored while stopped");

        mc_half = 23;
        mc_run = 1'b1;
        idle(2 * TO + 10);
        expect_rd(8'h07, "R8 monitor cleared, select held");
        do_write(8'h03, 1'b1);
        expect_rd(8'h03, "R8 software returns to main clock");

        mc_run = 1'b0;
        idle(2 * TO + 10);
        expect_rd(8'h0F, "R6 second stop detected");
        do_write(8'h04, 1'b1);
        expect_rd(8'h04, "R9 disarm clears monitor");
        idle(2 * TO + 10);
        expect_rd(8'h04, "R9 stopped clock ignored while disarmed");
        do_write(8'h00, 1'b1);
        expect_rd(8'h00, "R9 select free while disarmed");

        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule